// File: doc/BRIEF.md
# Two-Wire Register-Access Target

This block is a target (slave) on a two-wire serial bus. It gives a bus host read and write access to a bank of byte-wide control registers that sit outside the block. The block does not drive SDA high. Its open-drain output is modelled as an enable: when the enable is high, the pad pulls the line low. The register bank is reached through a plain internal port. That port carries an address, write data, a one-cycle write strobe, and read data that is returned combinationally for the address presented.

A transaction opens with a start condition. The host then sends a 7-bit device address and a direction bit. In a write-direction transaction, the first byte after the address sets an internal register pointer. Every further byte is stored at the pointer, and the pointer then advances. To read, the host loads the pointer with a write-direction transaction, issues a repeated start and addresses the block for reading. The block then returns bytes from the pointer, moving on after each byte the host acknowledges. The pointer keeps its value across repeated starts and stop conditions.

Top module: `twi_reg_target`

## Requirements
- R1: Bit activity on SCL that is not preceded by a start condition (SDA falling while SCL is high) is ignored: no acknowledge and no register write. A stop condition (SDA rising while SCL is high) returns the block to idle.
- R2: After a start, the block takes the first seven bits (MSB first) as a device address and the eighth bit as the direction (1 = read, 0 = write). On a match it acknowledges by pulling SDA low during the ninth clock.
- R3: On an address mismatch, the block neither acknowledges nor drives SDA for the rest of the transaction, and it performs no register write.
- R4: In a write-direction transaction, the first byte after the address acknowledge is loaded into the register pointer and acknowledged.
- R5: Each further byte of a write-direction transaction is presented on the register port as a one-cycle write strobe at the current pointer, and is acknowledged. The pointer then increases by one.
- R6: A repeated start followed by a matching read-direction address makes the block transmit data from the register at the pointer, MSB first.
- R7: When the host acknowledges a read byte (SDA low in the ninth clock), the pointer increases by one and the next register is transmitted. When the host does not acknowledge, the block releases SDA and drives it no more until the next start.
- R8: The pointer wraps from 255 to 0 when it increases, for both writes and reads.
- R9: The pointer keeps its value across a stop condition, so that a later read-direction transaction without a pointer byte continues from it.
- R10: A start condition seen in the middle of a byte restarts address reception. The incomplete byte is discarded, and no write is made.
- R11: The SDA output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | Pulls SDA low when high; line released when low |
| reg_addr_o | output | PTR_W | Register-bank address (the pointer) |
| reg_wdata_o | output | 8 | Write data for the register bank |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data of the register at reg_addr_o |

## Verification
The bench builds the block with DEV_ADDR = 7'h5A, SYNC_STAGES = 3 and PTR_W = 8. A three-stage synchroniser lengthens the delay between an SCL edge and the block's reaction. This checks that the enable still moves only inside the low phase with the bench's six-cycle quarter bit. A full 8-bit pointer makes the 255-to-0 wrap reachable in both write and read bursts. The chosen address has both polarities among its bits, so a one-bit-flipped address exercises the mismatch path in each direction.

// File: rtl/twi_reg_pkg.sv
`timescale 1ns/1ps
package twi_reg_pkg;

   localparam int BYTE_W = 8;
   localparam int BIT_IDX_W = $clog2(BYTE_W);

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_DEVADR,
      PH_DEVACK,
      PH_PTRRX,
      PH_PTRACK,
      PH_WRRX,
      PH_WRACK,
      PH_RDTX,
      PH_HOSTACK,
      PH_SKIP
   } phase_t;

   typedef struct packed {
      logic scl;
      logic sda;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_ev_t;

endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
module twi_line_sync
   import twi_reg_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic    clk_i,
   input  logic    rst_ni,
   input  logic    scl_i,
   input  logic    sda_i,
   output bus_ev_t ev_o
);

   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("twi_line_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_pipe;
   logic [SYNC_STAGES-1:0] sda_pipe;
   logic                   scl_prev;
   logic                   sda_prev;
   logic                   scl_now;
   logic                   sda_now;

   // The bus idles high, so all stages reset to one.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_prev <= 1'b1;
         sda_prev <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
         scl_prev <= scl_pipe[LAST];
         sda_prev <= sda_pipe[LAST];
      end
   end

   assign scl_now = scl_pipe[LAST];
   assign sda_now = sda_pipe[LAST];

   always_comb begin
      ev_o.scl      = scl_now;
      ev_o.sda      = sda_now;
      ev_o.scl_rise = scl_now & ~scl_prev;
      ev_o.scl_fall = ~scl_now & scl_prev;
      ev_o.start    = scl_now & scl_prev & sda_prev & ~sda_now;
      ev_o.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
   end

endmodule

// File: rtl/twi_ptr_reg.sv
`timescale 1ns/1ps
module twi_ptr_reg
   import twi_reg_pkg::*;
#(
   parameter int PTR_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] load_val_i,
   input  logic              inc_i,
   output logic [PTR_W-1:0]  ptr_o
);

   if (PTR_W < 1 || PTR_W > BYTE_W) begin : g_bad_width
      $error("twi_ptr_reg: PTR_W must lie between 1 and 8");
   end

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] load_slice;

   if (PTR_W == BYTE_W) begin : g_full
      assign load_slice = load_val_i;
   end else begin : g_narrow
      assign load_slice = load_val_i[PTR_W-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q <= '0;
      end else if (load_i) begin
         ptr_q <= load_slice;
      end else if (inc_i) begin
         ptr_q <= ptr_q + PTR_W'(1);
      end
   end

   assign ptr_o = ptr_q;

   // R8
   ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ptr_q) |-> ($past(load_i) || ptr_q == $past(ptr_q) + PTR_W'(1)));

endmodule

// File: rtl/twi_byte_seq.sv
`timescale 1ns/1ps
module twi_byte_seq
   import twi_reg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h2C
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  bus_ev_t           ev_i,
   input  logic [BYTE_W-1:0] rdata_i,
   output logic              ptr_load_o,
   output logic [BYTE_W-1:0] ptr_val_o,
   output logic              ptr_inc_o,
   output logic              we_o,
   output logic [BYTE_W-1:0] wdata_o,
   output logic              sda_oe_o
);

   localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

   phase_t               phase_q;
   logic [BIT_IDX_W-1:0] bit_q;
   logic [BYTE_W-1:0]    rx_q;
   logic [BYTE_W-1:0]    tx_q;
   logic [BYTE_W-1:0]    rx_byte;
   logic                 drive_q;
   logic                 rnw_q;
   logic                 we_q;
   logic                 ld_q;
   logic                 inc_q;
   logic [BYTE_W-1:0]    wdata_q;
   logic [BYTE_W-1:0]    ldval_q;

   assign rx_byte = {rx_q[BYTE_W-2:0], ev_i.sda};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         bit_q   <= '0;
         rx_q    <= '0;
         tx_q    <= '1;
         drive_q <= 1'b0;
         rnw_q   <= 1'b0;
         we_q    <= 1'b0;
         ld_q    <= 1'b0;
         inc_q   <= 1'b0;
         wdata_q <= '0;
         ldval_q <= '0;
      end else begin
         we_q  <= 1'b0;
         ld_q  <= 1'b0;
         inc_q <= 1'b0;
         if (ev_i.stop) begin
            phase_q <= PH_IDLE;
            drive_q <= 1'b0;
         end else if (ev_i.start) begin
            phase_q <= PH_DEVADR;
            bit_q   <= '0;
            drive_q <= 1'b0;
         end else if (ev_i.scl_rise) begin
            unique case (phase_q)
               PH_DEVADR, PH_PTRRX, PH_WRRX: begin
                  rx_q  <= rx_byte;
                  bit_q <= bit_q + BIT_IDX_W'(1);
                  if (bit_q == LAST_BIT) begin
                     if (phase_q == PH_DEVADR) begin
                        if (rx_byte[BYTE_W-1:1] == DEV_ADDR) begin
                           phase_q <= PH_DEVACK;
                           rnw_q   <= rx_byte[0];
                        end else begin
                           phase_q <= PH_SKIP;
                        end
                     end else if (phase_q == PH_PTRRX) begin
                        ld_q    <= 1'b1;
                        ldval_q <= rx_byte;
                        phase_q <= PH_PTRACK;
                     end else begin
                        we_q    <= 1'b1;
                        wdata_q <= rx_byte;
                        phase_q <= PH_WRACK;
                     end
                  end
               end
               PH_HOSTACK: begin
                  if (!ev_i.sda) begin
                     inc_q <= 1'b1;
                  end else begin
                     phase_q <= PH_SKIP;
                  end
               end
               default: ;
            endcase
         end else if (ev_i.scl_fall) begin
            unique case (phase_q)
               PH_DEVACK, PH_PTRACK, PH_WRACK: begin
                  if (!drive_q) begin
                     drive_q <= 1'b1;
                  end else begin
                     drive_q <= 1'b0;
                     bit_q   <= '0;
                     if (phase_q == PH_DEVACK) begin
                        if (rnw_q) begin
                           phase_q <= PH_RDTX;
                           tx_q    <= rdata_i;
                        end else begin
                           phase_q <= PH_PTRRX;
                        end
                     end else begin
                        phase_q <= PH_WRRX;
                        inc_q   <= (phase_q == PH_WRACK);
                     end
                  end
               end
               PH_RDTX: begin
                  tx_q  <= {tx_q[BYTE_W-2:0], 1'b1};
                  bit_q <= bit_q + BIT_IDX_W'(1);
                  if (bit_q == LAST_BIT) begin
                     phase_q <= PH_HOSTACK;
                  end
               end
               PH_HOSTACK: begin
                  phase_q <= PH_RDTX;
                  tx_q    <= rdata_i;
                  bit_q   <= '0;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe_o   = drive_q | ((phase_q == PH_RDTX) & ~tx_q[BYTE_W-1]);
   assign we_o       = we_q;
   assign wdata_o    = wdata_q;
   assign ptr_load_o = ld_q;
   assign ptr_val_o  = ldval_q;
   assign ptr_inc_o  = inc_q;

   // R11
   oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sda_oe_o) |-> !ev_i.scl);

   // R3
   skip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_SKIP) |-> !sda_oe_o);

   // R10
   restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i.start |=> (phase_q == PH_DEVADR && bit_q == '0));

   // R1
   stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i.stop |=> (phase_q == PH_IDLE && !sda_oe_o));

   // R5
   we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_o |=> !we_o);

endmodule

// File: rtl/twi_reg_target.sv
`timescale 1ns/1ps
module twi_reg_target
   import twi_reg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h2C,
   parameter int         SYNC_STAGES = 2,
   parameter int         PTR_W       = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe_o,
   output logic [PTR_W-1:0] reg_addr_o,
   output logic [7:0]       reg_wdata_o,
   output logic             reg_we_o,
   input  logic [7:0]       reg_rdata_i
);

   bus_ev_t           ev;
   logic              ptr_load;
   logic [BYTE_W-1:0] ptr_val;
   logic              ptr_inc;

   twi_line_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_line (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev_o  (ev)
   );

   twi_byte_seq #(
      .DEV_ADDR(DEV_ADDR)
   ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ev_i      (ev),
      .rdata_i   (reg_rdata_i),
      .ptr_load_o(ptr_load),
      .ptr_val_o (ptr_val),
      .ptr_inc_o (ptr_inc),
      .we_o      (reg_we_o),
      .wdata_o   (reg_wdata_o),
      .sda_oe_o  (sda_oe_o)
   );

   twi_ptr_reg #(
      .PTR_W(PTR_W)
   ) u_ptr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (ptr_load),
      .load_val_i(ptr_val),
      .inc_i     (ptr_inc),
      .ptr_o     (reg_addr_o)
   );

endmodule

// File: tb/test_twi_reg_target.sv
`timescale 1ns/1ps
module test_twi_reg_target;

   localparam int         Q    = 6;
   localparam logic [6:0] DEV  = 7'h5A;
   localparam int         SYNC = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_line;
   logic       sda_oe;
   logic [7:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic       reg_we;

   logic [7:0] mem   [256];
   logic [7:0] model [256];
   logic [7:0] exp_ptr;
   int         total = 0;
   int         bad = 0;
   int         wr_cnt = 0;
   int         oe_viol = 0;
   logic       oe_prev = 1'b0;
   logic       done = 1'b0;

   always #2.5 clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign reg_rdata = mem[reg_addr];

   twi_reg_target #(
      .DEV_ADDR(DEV),
      .SYNC_STAGES(SYNC),
      .PTR_W(8)
   ) i_twi_reg_target (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_line),
      .sda_oe_o   (sda_oe),
      .reg_addr_o (reg_addr),
      .reg_wdata_o(reg_wdata),
      .reg_we_o   (reg_we),
      .reg_rdata_i(reg_rdata)
   );

   always @(posedge clk) begin
      if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
         wr_cnt <= wr_cnt + 1;
      end
      // R11: enable may only move while the bus clock is low
      if (rst_n && sda_oe !== oe_prev && scl_m) oe_viol <= oe_viol + 1;
      oe_prev <= sda_oe;
   end

   function automatic logic [7:0] seed_val(input int i);
      return 8'((i * 29 + 7) ^ (i >> 3));
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic hold();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hold();
      scl_m = 1'b1; hold();
      sda_m = 1'b0; hold();
      scl_m = 1'b0; hold();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hold();
      scl_m = 1'b1; hold();
      sda_m = 1'b1; hold();
   endtask

   task automatic clock_bit(input logic b, output logic seen);
      sda_m = b;    hold();
      scl_m = 1'b1; hold();
      seen = sda_line; hold();
      scl_m = 1'b0; hold();
   endtask

   task automatic put_byte(input logic [7:0] v, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
      clock_bit(1'b1, s);
      acked = ~s;
   endtask

   task automatic get_byte(input logic host_ack, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clock_bit(1'b1, s);
         v[i] = s;
      end
      clock_bit(~host_ack, s);
   endtask

   // Write burst: pointer byte then n data bytes (R4, R5, R8).
   task automatic wr_burst(input logic [7:0] p, input int n, input logic end_stop);
      logic       a;
      logic [7:0] d;
      bus_start();
      put_byte({DEV, 1'b0}, a);
      check("R2 write-address ack", a, 1);
      put_byte(p, a);
      check("R4 pointer byte ack", a, 1);
      exp_ptr = p;
      for (int i = 0; i < n; i++) begin
         d = 8'($urandom);
         put_byte(d, a);
         check("R5 data byte ack", a, 1);
         model[exp_ptr] = d;
         exp_ptr = exp_ptr + 8'd1;
      end
      if (end_stop) bus_stop();
   endtask

   // Read burst from the current pointer (R6, R7, R9); ends with NACK and stop.
   task automatic rd_burst(input int n, input string req);
      logic       a;
      logic [7:0] v;
      bus_start();
      put_byte({DEV, 1'b1}, a);
      check("R6 read-address ack", a, 1);
      for (int i = 0; i < n; i++) begin
         get_byte(i < n - 1, v);
         check(req, v, model[exp_ptr]);
         if (i < n - 1) exp_ptr = exp_ptr + 8'd1;
      end
      bus_stop();
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic       a;
      logic [7:0] v;
      int         base;
      int         mism;
      void'($urandom(32'h00C0FFEE));
      for (int i = 0; i < 256; i++) begin
         mem[i]   = seed_val(i);
         model[i] = seed_val(i);
      end
      exp_ptr = 8'd0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 reset: SDA released", sda_oe, 0);
      check("R1 reset: no write strobe", reg_we, 0);

      // R1: clocking bits with no start is ignored
      base = wr_cnt;
      scl_m = 1'b0; hold();
      put_byte({DEV, 1'b0}, a);
      check("R1 no ack without start", a, 0);
      put_byte(8'h33, a);
      check("R1 no ack for stray byte", a, 0);
      sda_m = 1'b1; hold();
      scl_m = 1'b1; hold();
      check("R1 no write without start", wr_cnt - base, 0);

      // R3: mismatched address, both directions
      bus_start();
      put_byte({DEV ^ 7'h01, 1'b0}, a);
      check("R3 mismatch write address not acked", a, 0);
      put_byte(8'h10, a);
      check("R3 pointer byte not acked", a, 0);
      put_byte(8'hA5, a);
      check("R3 data byte not acked", a, 0);
      bus_stop();
      check("R3 no write after mismatch", wr_cnt - base, 0);
      bus_start();
      put_byte({DEV ^ 7'h40, 1'b1}, a);
      check("R3 mismatch read address not acked", a, 0);
      get_byte(1'b1, v);
      check("R3 line stays released", v, 8'hFF);
      bus_stop();

      // R4/R5: write burst, then R9 read continuing after stop
      wr_burst(8'h20, 4, 1'b1);
      check("R5 pointer advanced by writes", exp_ptr, 8'h24);
      for (int i = 0; i < 4; i++) check("R5 stored byte", mem[8'h20 + i], model[8'h20 + i]);
      rd_burst(2, "R9 read continues from kept pointer");

      // R6/R7: pointer write, repeated start, multi-byte read
      wr_burst(8'h20, 0, 1'b0);
      rd_burst(4, "R6 R7 read after repeated start");

      // R8: wrap on writes, then on reads
      wr_burst(8'hFE, 4, 1'b1);
      check("R8 pointer wrapped on writes", exp_ptr, 8'h02);
      check("R8 byte stored at 0x00", mem[0], model[0]);
      wr_burst(8'hFF, 0, 1'b0);
      rd_burst(3, "R8 read across wrap");

      // R10: start in the middle of a data byte
      base = wr_cnt;
      wr_burst(8'h40, 0, 1'b0);
      for (int i = 0; i < 3; i++) clock_bit(1'b0, a);
      rd_burst(1, "R10 restart keeps pointer, read 0x40");
      check("R10 partial byte not written", wr_cnt - base, 0);

      // R7: after host NACK the target stays off the line
      wr_burst(8'h60, 0, 1'b0);
      bus_start();
      put_byte({DEV, 1'b1}, a);
      check("R6 read-address ack", a, 1);
      get_byte(1'b0, v);
      check("R7 byte before NACK", v, model[8'h60]);
      get_byte(1'b0, v);
      check("R7 released after NACK", v, 8'hFF);
      bus_stop();
      exp_ptr = 8'h60;

      // Random mix of bursts
      for (int k = 0; k < 20; k++) begin
         logic [7:0] p;
         int         n;
         int         mode;
         p    = 8'($urandom);
         n    = 1 + int'($urandom % 5);
         mode = int'($urandom % 3);
         if (mode == 0) begin
            wr_burst(p, n, 1'b1);
            wr_burst(p, 0, 1'b0);
            rd_burst(n, "R6 R7 random readback");
         end else if (mode == 1) begin
            wr_burst(p, n, 1'b0);
            rd_burst(2, "R6 read after repeated start past burst");
         end else begin
            wr_burst(p, n, 1'b1);
            rd_burst(1 + n, "R9 read after stop");
         end
      end

      mism = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== model[i]) mism++;
      check("R5 final register image", mism, 0);
      check("R11 enable changes only while SCL low", oe_viol, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule